// File: doc/BRIEF.md
# Two-Wire Target Register Access Engine

This block handles the byte-level transactions of a two-wire serial target. A bus front end that has already decoded the line activity drives it. That front end reports start and repeated start conditions, stop conditions, the received address byte, each received data byte and each request for a byte to transmit. The engine answers with an acknowledge decision for every byte it receives and a data byte for every byte the controller asks for. It also passes configuration writes on to the conversion sequencer.

A read returns the 16-bit conversion result, high byte first, then the current configuration byte. Every byte requested after those three is all ones. The result and the configuration are captured together when the read address is accepted, so the bytes of one read all describe the same moment. A write stores its first data byte as the new configuration. That byte is handed to the sequencer as a one-cycle strobe. Any later data byte in the same write gets no acknowledge and is dropped.

Top module: `twt_regaccess`

## Requirements
- R1: While reset is high and after it is released, `ack_vld`, `ack_out`, `tx_vld`, `tx_byte` and `cfg_wr_stb` are all zero.
- R2: An address byte is acknowledged only when its bits [7:1] equal the parameter `TGT_ADDR`; bit 0 selects read (1) or write (0). `ack_vld` and `ack_out` answer one cycle after `addr_valid`. After a mismatch, every data byte in that transaction is not acknowledged and every requested byte is 0xFF.
- R3: In a read, the first requested byte is result[15:8], the second is result[7:0] and the third is the configuration byte. Each byte appears on `tx_byte` with `tx_vld` one cycle after `tx_req`.
- R4: The fourth and every later byte requested in the same read is 0xFF.
- R5: The result and configuration bytes of a read are the values of `result_in` and `cfg_in` in the cycle the read address is accepted; later changes to these inputs do not alter that read.
- R6: A read that the controller ends with a stop after two bytes leaves no trace: the next read starts again with result[15:8].
- R7: The first data byte of a write is acknowledged, and in the same cycle as that acknowledge `cfg_wr_stb` pulses high for exactly one cycle with the byte on `cfg_wr_data`.
- R8: The second and later data bytes of a write are not acknowledged and raise no `cfg_wr_stb`.
- R9: A repeated start in the middle of a read resets the byte position, so the next read after it starts again with result[15:8].
- R10: A data byte received during a read is not acknowledged, raises no `cfg_wr_stb`, and does not advance the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_start | input | 1 | One-cycle pulse for a start or repeated start condition |
| bus_stop | input | 1 | One-cycle pulse for a stop condition |
| addr_valid | input | 1 | One-cycle pulse: the address byte is on `rx_byte` |
| rx_valid | input | 1 | One-cycle pulse: a data byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte (address or data) |
| tx_req | input | 1 | One-cycle pulse: the controller asks for a byte |
| result_in | input | 16 | Current conversion result from the sequencer |
| cfg_in | input | 8 | Current configuration from the sequencer |
| ack_vld | output | 1 | One-cycle pulse: `ack_out` holds the answer to the last received byte |
| ack_out | output | 1 | 1 means acknowledge, 0 means no acknowledge |
| tx_vld | output | 1 | One-cycle pulse: `tx_byte` holds the requested byte |
| tx_byte | output | 8 | Byte to transmit |
| cfg_wr_stb | output | 1 | One-cycle configuration write strobe |
| cfg_wr_data | output | 8 | Configuration byte to write |

## Verification
Every result comes out of a single register stage. The acknowledge, the configuration strobe and the transmit byte are therefore due exactly one cycle after the input pulse that caused them. The bench drives each pulse at a falling edge and removes it at the next falling edge. It reads the outputs at that same moment, half a cycle after the rising edge that registered them. The strobe is sampled in the same window as the acknowledge for each received byte, so a late or extra strobe shows up as a mismatch.

// File: rtl/twt_pkg.sv
package twt_pkg;

    localparam int BYTE_W    = 8;
    localparam int RES_BYTES = 2;
    localparam int RES_W     = RES_BYTES * BYTE_W;
    localparam logic [BYTE_W-1:0] PAD_BYTE = '1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_READ,
        PH_WRITE,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic [RES_W-1:0]  res;
        logic [BYTE_W-1:0] cfg;
    } snap_t;

    function automatic logic dir_is_read(input logic [BYTE_W-1:0] b);
        return b[0];
    endfunction

endpackage

// File: rtl/twt_addr_match.sv
module twt_addr_match
    import twt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h48
) (
    input  logic [BYTE_W-1:0] addr_byte,
    output logic              hit,
    output logic              rd
);
    always_comb begin
        hit = (addr_byte[BYTE_W-1:1] == TGT_ADDR);
        rd  = dir_is_read(addr_byte);
    end
endmodule

// File: rtl/twt_tx_sel.sv
module twt_tx_sel
    import twt_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0]  idx,
    input  snap_t             snap,
    output logic [BYTE_W-1:0] byte_o
);
    always_comb begin
        byte_o = PAD_BYTE;
        if (idx == IDX_W'(RES_BYTES))
            byte_o = snap.cfg;
        for (int i = 0; i < RES_BYTES; i++) begin
            if (idx == IDX_W'(i))
                byte_o = snap.res[RES_W-1-BYTE_W*i -: BYTE_W];
        end
    end
endmodule

// File: rtl/twt_regaccess.sv
module twt_regaccess
    import twt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              addr_valid,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_req,
    input  logic [RES_W-1:0]  result_in,
    input  logic [BYTE_W-1:0] cfg_in,
    output logic              ack_vld,
    output logic              ack_out,
    output logic              tx_vld,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              cfg_wr_stb,
    output logic [BYTE_W-1:0] cfg_wr_data
);
    localparam int LAST  = RES_BYTES + 1;
    localparam int IDX_W = $clog2(LAST + 1);

    phase_t            phase;
    logic [IDX_W-1:0]  idx;
    logic              wr_taken;
    snap_t             snap;
    logic              addr_hit;
    logic              addr_rd;
    logic [BYTE_W-1:0] sel_byte;

    twt_addr_match #(.TGT_ADDR(TGT_ADDR)) i_match (
        .addr_byte (rx_byte),
        .hit       (addr_hit),
        .rd        (addr_rd)
    );

    twt_tx_sel #(.IDX_W(IDX_W)) i_sel (
        .idx    (idx),
        .snap   (snap),
        .byte_o (sel_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            idx         <= '0;
            wr_taken    <= 1'b0;
            snap        <= '0;
            ack_vld     <= 1'b0;
            ack_out     <= 1'b0;
            tx_vld      <= 1'b0;
            tx_byte     <= '0;
            cfg_wr_stb  <= 1'b0;
            cfg_wr_data <= '0;
        end else begin
            ack_vld    <= 1'b0;
            tx_vld     <= 1'b0;
            cfg_wr_stb <= 1'b0;
            if (bus_start || bus_stop) begin
                phase    <= PH_IDLE;
                idx      <= '0;
                wr_taken <= 1'b0;
            end else if (addr_valid) begin
                ack_vld <= 1'b1;
                if (phase == PH_IDLE && addr_hit) begin
                    phase    <= addr_rd ? PH_READ : PH_WRITE;
                    ack_out  <= 1'b1;
                    snap.res <= result_in;
                    snap.cfg <= cfg_in;
                end else begin
                    phase   <= PH_SKIP;
                    ack_out <= 1'b0;
                end
            end else if (rx_valid) begin
                ack_vld <= 1'b1;
                if (phase == PH_WRITE && !wr_taken) begin
                    ack_out     <= 1'b1;
                    cfg_wr_stb  <= 1'b1;
                    cfg_wr_data <= rx_byte;
                    wr_taken    <= 1'b1;
                end else begin
                    ack_out <= 1'b0;
                end
            end else if (tx_req) begin
                tx_vld <= 1'b1;
                if (phase == PH_READ) begin
                    tx_byte <= sel_byte;
                    if (idx != IDX_W'(LAST))
                        idx <= idx + 1'b1;
                end else begin
                    tx_byte <= PAD_BYTE;
                end
            end
        end
    end
endmodule

// File: rtl/twt_regaccess_chk.sv
module twt_regaccess_chk
    import twt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h48
) (
    input logic              clk,
    input logic              rst,
    input logic              addr_valid,
    input logic              rx_valid,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              tx_req,
    input logic              ack_vld,
    input logic              ack_out,
    input logic              tx_vld,
    input logic              cfg_wr_stb
);
    // R7
    stb_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_stb |-> (ack_vld && ack_out));

    // R7
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_stb |=> !cfg_wr_stb);

    // R2
    ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ack_vld |-> $past(addr_valid || rx_valid));

    // R3
    tx_cause_chk: assert property (@(posedge clk) disable iff (rst)
        tx_vld |-> $past(tx_req));

    // R2
    addr_miss_nak_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && $past(addr_valid) &&
         ($past(rx_byte[BYTE_W-1:1]) != TGT_ADDR)) |-> !ack_out);
endmodule

bind twt_regaccess twt_regaccess_chk #(.TGT_ADDR(TGT_ADDR)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_valid (addr_valid),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .tx_req     (tx_req),
    .ack_vld    (ack_vld),
    .ack_out    (ack_out),
    .tx_vld     (tx_vld),
    .cfg_wr_stb (cfg_wr_stb)
);

// File: tb/test_twt_regaccess.sv
module test_twt_regaccess;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_start = 1'b0, bus_stop = 1'b0;
    logic        addr_valid = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [15:0] result_in = 16'h3C81;
    logic [7:0]  cfg_in = 8'h8C;
    logic        ack_vld, ack_out, tx_vld, cfg_wr_stb;
    logic [7:0]  tx_byte, cfg_wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    twt_regaccess #(.TGT_ADDR(7'h48)) i_twt_regaccess (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .addr_valid(addr_valid), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_req(tx_req), .result_in(result_in), .cfg_in(cfg_in),
        .ack_vld(ack_vld), .ack_out(ack_out), .tx_vld(tx_vld),
        .tx_byte(tx_byte), .cfg_wr_stb(cfg_wr_stb), .cfg_wr_data(cfg_wr_data)
    );

    // sequencer model: a strobe updates the configuration it reports
    always @(posedge clk) if (!rst && cfg_wr_stb) cfg_in <= cfg_wr_data;

    localparam logic [2:0] OP_START = 3'd0, OP_STOP = 3'd1, OP_ADDR = 3'd2,
                           OP_RX = 3'd3, OP_TX = 3'd4;
    // {op, data, expected, requirement}
    localparam int NV = 24;
    localparam logic [22:0] VEC [NV] = '{
        {OP_START, 8'h00, 8'h00, 4'd0},
        {OP_ADDR,  8'h91, 8'h01, 4'd2},
        {OP_TX,    8'h00, 8'h3C, 4'd3},
        {OP_TX,    8'h00, 8'h81, 4'd3},
        {OP_TX,    8'h00, 8'h8C, 4'd3},
        {OP_TX,    8'h00, 8'hFF, 4'd4},
        {OP_TX,    8'h00, 8'hFF, 4'd4},
        {OP_STOP,  8'h00, 8'h00, 4'd0},
        {OP_START, 8'h00, 8'h00, 4'd0},
        {OP_ADDR,  8'h90, 8'h01, 4'd2},
        {OP_RX,    8'h0F, 8'h01, 4'd7},
        {OP_RX,    8'h33, 8'h00, 4'd8},
        {OP_RX,    8'h44, 8'h00, 4'd8},
        {OP_STOP,  8'h00, 8'h00, 4'd0},
        {OP_START, 8'h00, 8'h00, 4'd0},
        {OP_ADDR,  8'h91, 8'h01, 4'd2},
        {OP_TX,    8'h00, 8'h3C, 4'd3},
        {OP_TX,    8'h00, 8'h81, 4'd3},
        {OP_TX,    8'h00, 8'h0F, 4'd7},
        {OP_STOP,  8'h00, 8'h00, 4'd0},
        {OP_START, 8'h00, 8'h00, 4'd0},
        {OP_ADDR,  8'h93, 8'h00, 4'd2},
        {OP_RX,    8'h55, 8'h00, 4'd2},
        {OP_TX,    8'h00, 8'hFF, 4'd2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive one pulse at a falling edge, release and leave outputs readable
    task automatic do_op(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        rx_byte    = d;
        bus_start  = (op == OP_START);
        bus_stop   = (op == OP_STOP);
        addr_valid = (op == OP_ADDR);
        rx_valid   = (op == OP_RX);
        tx_req     = (op == OP_TX);
        @(negedge clk);
        {bus_start, bus_stop, addr_valid, rx_valid, tx_req} = '0;
    endtask

    task automatic exp_ack(input bit a, input bit stb, input string req);
        chk(ack_vld && ack_out == a, req, {ack_vld, ack_out}, {1'b1, a});
        chk(cfg_wr_stb == stb, req, cfg_wr_stb, stb);
    endtask

    task automatic exp_tx(input logic [7:0] b, input string req);
        chk(tx_vld && tx_byte == b, req, {tx_vld, tx_byte}, {1'b1, b});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs held low during reset
        chk({ack_vld, ack_out, tx_vld, tx_byte, cfg_wr_stb} == '0, "R1",
            {ack_vld, ack_out, tx_vld, tx_byte, cfg_wr_stb}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({ack_vld, ack_out, tx_vld, tx_byte, cfg_wr_stb} == '0, "R1",
            {ack_vld, ack_out, tx_vld, tx_byte, cfg_wr_stb}, 0);

        for (int i = 0; i < NV; i++) begin
            automatic logic [2:0] op  = VEC[i][22:20];
            automatic logic [7:0] d   = VEC[i][19:12];
            automatic logic [7:0] e   = VEC[i][11:4];
            automatic string      req = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
            do_op(op, d);
            if (op == OP_ADDR) chk(ack_vld && ack_out == e[0], req, ack_out, e[0]);
            else if (op == OP_RX) exp_ack(e[0], e[0], req);
            else if (op == OP_TX) exp_tx(e, req);
        end
        do_op(OP_STOP, 8'h00);

        // R5 result changes after the address do not affect the read
        do_op(OP_START, 0); do_op(OP_ADDR, 8'h91);
        result_in = 16'h1234;
        do_op(OP_TX, 0); exp_tx(8'h3C, "R5");
        do_op(OP_TX, 0); exp_tx(8'h81, "R5");
        do_op(OP_STOP, 0);

        // R6 two-byte read then stop, next read restarts at high byte
        do_op(OP_START, 0); do_op(OP_ADDR, 8'h91);
        do_op(OP_TX, 0); exp_tx(8'h12, "R6");
        do_op(OP_TX, 0); exp_tx(8'h34, "R6");
        do_op(OP_STOP, 0);
        do_op(OP_START, 0); do_op(OP_ADDR, 8'h91);
        do_op(OP_TX, 0); exp_tx(8'h12, "R6");

        // R9 repeated start mid-read
        do_op(OP_START, 0); do_op(OP_ADDR, 8'h91);
        do_op(OP_TX, 0); exp_tx(8'h12, "R9");

        // R10 data byte during read: nak, no strobe, position kept
        do_op(OP_RX, 8'h55); exp_ack(1'b0, 1'b0, "R10");
        do_op(OP_TX, 0); exp_tx(8'h34, "R10");
        do_op(OP_TX, 0); exp_tx(8'h0F, "R10");
        do_op(OP_STOP, 0);

        // R7 strobe lasts one cycle; R8 later write bytes give no strobe
        do_op(OP_START, 0); do_op(OP_ADDR, 8'h90);
        do_op(OP_RX, 8'hA7); exp_ack(1'b1, 1'b1, "R7");
        chk(cfg_wr_data == 8'hA7, "R7", cfg_wr_data, 8'hA7);
        @(negedge clk);
        chk(!cfg_wr_stb, "R7", cfg_wr_stb, 0);
        do_op(OP_RX, 8'h01); exp_ack(1'b0, 1'b0, "R8");
        do_op(OP_STOP, 0);
        do_op(OP_START, 0); do_op(OP_ADDR, 8'h91);
        do_op(OP_TX, 0); do_op(OP_TX, 0);
        do_op(OP_TX, 0); exp_tx(8'hA7, "R8");
        do_op(OP_TX, 0); exp_tx(8'hFF, "R4");
        do_op(OP_STOP, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule